// File: doc/BRIEF.md
# Audio Master and Bit Clock Generator

This block produces the three clocks an audio serial port presents to a codec: a master clock (MCLK), a bit clock and a left/right frame clock. It runs from a reference clock at twice the port rate, so one sample period lasts 1024 reference cycles when the port runs at 512 x fs, and 768 when it runs at 384 x fs. A base-rate select and a 3-bit multiplier field set the MCLK ratio as a power-of-two division of the port rate. A word-size option sets the bit clock density to 32 or 48 bit clocks per sample period.

A run input starts and stops clock generation. A slave input lets a port take its bit clock and frame clock from a partner port that owns the clocks. In slave mode the local dividers are held at the frame start, the pass-through clocks appear on the outputs and the output-drive enable is withdrawn. All counters are free-running and aligned to the frame start, so every clock begins low when a frame starts and has a 50 percent duty cycle.

Top module: `audio_clkgen`

## Requirements
- R1: After a synchronous reset, with master mode selected, `mclk_o`, `bclk_o` and `fclk_o` are low and `clk_oe_o` is high in the first cycle after reset is released.
- R2: In master mode while running, one frame lasts 1024 reference cycles when `base384_i` is 0 and 768 when it is 1; `fclk_o` is low for the first half of the frame (left channel) and high for the second half.
- R3: With `base384_i` = 0, `mult_i` values 0, 1, 2, 3 and 4 give an MCLK period of 2, 4, 8, 16 and 32 reference cycles (512, 256, 128, 64 and 32 x fs), 50 percent duty, low at the frame start.
- R4: With `base384_i` = 1, `mult_i` values 0, 1, 2 and 3 give an MCLK period of 2, 4, 8 and 16 reference cycles (384, 192, 96 and 48 x fs), 50 percent duty, low at the frame start.
- R5: A `mult_i` value above 4 with the 512x base, or above 3 with the 384x base, holds `mclk_o` low.
- R6: With `wide_i` = 0 the frame carries 32 bit clocks: `bclk_o` is low at frame start and toggles every 16 reference cycles with the 512x base, every 12 with the 384x base.
- R7: With `wide_i` = 1 and the 384x base the frame carries 48 bit clocks: `bclk_o` toggles every 8 reference cycles.
- R8: With the 512x base, `wide_i` has no effect; the frame keeps 32 bit clocks.
- R9: While `slave_i` is 1, `bclk_o` follows `ext_bclk_i` and `fclk_o` follows `ext_fclk_i` in the same cycle, `mclk_o` is low, `clk_oe_o` is low, and the local dividers restart at the frame start when `slave_i` returns to 0.
- R10: While `run_i` is 0 in master mode, `mclk_o`, `bclk_o` and `fclk_o` are low in the same cycle; after `run_i` rises the frame restarts at its first cycle.
- R11: A change of `mult_i` while running takes effect in the same cycle and does not disturb the phase of `bclk_o` or `fclk_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, twice the port rate |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Enables clock generation |
| slave_i | input | 1 | Take bit and frame clocks from the partner port |
| base384_i | input | 1 | 0: port at 512 x fs, 1: port at 384 x fs |
| mult_i | input | 3 | MCLK divide exponent (port clock / 2^mult_i) |
| wide_i | input | 1 | 48 bit clocks per frame (384x base only) |
| ext_bclk_i | input | 1 | Partner bit clock for slave mode |
| ext_fclk_i | input | 1 | Partner frame clock for slave mode |
| mclk_o | output | 1 | Codec master clock |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Left/right frame clock |
| clk_oe_o | output | 1 | High when this port drives its clock pins |

## Verification
A change of the MCLK multiplier and a bit clock toggle can land in the same reference cycle; the bench changes `mult_i` mid-frame while running and judges `mclk_o` against the new ratio immediately while `bclk_o` and `fclk_o` keep the phase counted from the last frame start. Equally, dropping `slave_i` while running coincides with the local dividers leaving their hold, and the bench checks that the first master cycle afterwards is the first cycle of a fresh frame. The reference model counts frame position as a plain integer and derives each expected clock by division, compared on every falling edge.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    localparam int RATIO_HI    = 512;
    localparam int RATIO_LO    = 384;
    localparam int BITS_STD    = 32;
    localparam int BITS_WIDE   = 48;
    localparam int MULT_W      = 3;
    localparam int MULT_MAX_HI = 4;
    localparam int MULT_MAX_LO = 3;
    localparam int PHASE_W     = $clog2(2 * RATIO_HI);
    localparam int BDIV_W      = $clog2(RATIO_HI / BITS_STD) + 1;

    typedef enum logic {
        BASE_512 = 1'b0,
        BASE_384 = 1'b1
    } base_e;

    typedef struct packed {
        base_e             base;
        logic [MULT_W-1:0] mult;
        logic              wide;
    } clk_cfg_t;

    function automatic logic [PHASE_W-1:0] frame_last(base_e b);
        return (b == BASE_384) ? PHASE_W'(2 * RATIO_LO - 1)
                               : PHASE_W'(2 * RATIO_HI - 1);
    endfunction

    function automatic logic [BDIV_W-1:0] bit_half_last(clk_cfg_t c);
        if (c.base == BASE_384 && c.wide)
            return BDIV_W'(RATIO_LO / BITS_WIDE - 1);
        else if (c.base == BASE_384)
            return BDIV_W'(RATIO_LO / BITS_STD - 1);
        else
            return BDIV_W'(RATIO_HI / BITS_STD - 1);
    endfunction

    function automatic logic mult_ok(clk_cfg_t c);
        if (c.base == BASE_384)
            return c.mult <= MULT_W'(MULT_MAX_LO);
        else
            return c.mult <= MULT_W'(MULT_MAX_HI);
    endfunction

endpackage

// File: rtl/audio_clkgen_phase.sv
module audio_clkgen_phase
    import audio_clkgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [PHASE_W-1:0] last,
    output logic [PHASE_W-1:0] phase,
    output logic               wrap
);
    assign wrap = (phase >= last);

    always_ff @(posedge clk) begin
        if (rst || hold)
            phase <= '0;
        else if (wrap)
            phase <= '0;
        else
            phase <= phase + PHASE_W'(1);
    end
endmodule

// File: rtl/audio_clkgen_mclk.sv
module audio_clkgen_mclk
    import audio_clkgen_pkg::*;
(
    input  logic [PHASE_W-1:0] phase,
    input  clk_cfg_t           cfg,
    output logic               mclk
);
    logic [PHASE_W-1:0] shifted;

    always_comb begin
        shifted = phase >> cfg.mult;
        mclk    = mult_ok(cfg) & shifted[0];
    end
endmodule

// File: rtl/audio_clkgen_bdiv.sv
module audio_clkgen_bdiv
    import audio_clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              wrap,
    input  logic [BDIV_W-1:0] half_last,
    output logic              bclk
);
    logic [BDIV_W-1:0] bdiv;

    always_ff @(posedge clk) begin
        if (rst || hold || wrap) begin
            bdiv <= '0;
            bclk <= 1'b0;
        end else if (bdiv >= half_last) begin
            bdiv <= '0;
            bclk <= ~bclk;
        end else begin
            bdiv <= bdiv + BDIV_W'(1);
        end
    end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              slave_i,
    input  logic              base384_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic              wide_i,
    input  logic              ext_bclk_i,
    input  logic              ext_fclk_i,
    output logic              mclk_o,
    output logic              bclk_o,
    output logic              fclk_o,
    output logic              clk_oe_o
);
    clk_cfg_t           cfg;
    logic               hold;
    logic               wrap;
    logic [PHASE_W-1:0] last;
    logic [PHASE_W-1:0] phase;
    logic               mclk_int;
    logic               bclk_int;
    logic               fclk_int;

    always_comb begin
        cfg.base = base_e'(base384_i);
        cfg.mult = mult_i;
        cfg.wide = wide_i;
        hold     = ~run_i | slave_i;
        last     = frame_last(cfg.base);
    end

    audio_clkgen_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .last  (last),
        .phase (phase),
        .wrap  (wrap)
    );

    audio_clkgen_mclk u_mclk (
        .phase (phase),
        .cfg   (cfg),
        .mclk  (mclk_int)
    );

    audio_clkgen_bdiv u_bdiv (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .wrap      (wrap),
        .half_last (bit_half_last(cfg)),
        .bclk      (bclk_int)
    );

    // Second half of the frame carries the right channel.
    assign fclk_int = (phase > (last >> 1));

    always_comb begin
        clk_oe_o = ~slave_i;
        mclk_o   = ~hold & mclk_int;
        if (slave_i) begin
            bclk_o = ext_bclk_i;
            fclk_o = ext_fclk_i;
        end else begin
            bclk_o = run_i & bclk_int;
            fclk_o = run_i & fclk_int;
        end
    end
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk
    import audio_clkgen_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run_i,
    input logic              slave_i,
    input logic              base384_i,
    input logic [MULT_W-1:0] mult_i,
    input logic              ext_bclk_i,
    input logic              ext_fclk_i,
    input logic              mclk_o,
    input logic              bclk_o,
    input logic              fclk_o
);
    logic illegal_mult;
    assign illegal_mult = base384_i ? (mult_i > MULT_W'(MULT_MAX_LO))
                                    : (mult_i > MULT_W'(MULT_MAX_HI));

    assert_first_cycle_low_R1: assert property (@(posedge clk)
        disable iff (rst)
        ($past(rst) && !slave_i) |-> (!mclk_o && !bclk_o && !fclk_o));

    assert_fastest_mclk_toggles_R3: assert property (@(posedge clk)
        disable iff (rst)
        (run_i && !slave_i && mult_i == '0 && !$past(rst)
         && $past(run_i && !slave_i && mult_i == '0))
        |-> (mclk_o != $past(mclk_o)));

    assert_mclk_low_illegal_R5: assert property (@(posedge clk)
        disable iff (rst)
        illegal_mult |-> !mclk_o);

    assert_slave_passthrough_R9: assert property (@(posedge clk)
        disable iff (rst)
        slave_i |-> (bclk_o == ext_bclk_i && fclk_o == ext_fclk_i && !mclk_o));

    assert_stopped_quiet_R10: assert property (@(posedge clk)
        disable iff (rst)
        (!run_i && !slave_i) |-> (!mclk_o && !bclk_o && !fclk_o));
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .slave_i    (slave_i),
    .base384_i  (base384_i),
    .mult_i     (mult_i),
    .ext_bclk_i (ext_bclk_i),
    .ext_fclk_i (ext_fclk_i),
    .mclk_o     (mclk_o),
    .bclk_o     (bclk_o),
    .fclk_o     (fclk_o)
);

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_i = 1'b0;
    logic       slave_i = 1'b0;
    logic       base384_i = 1'b0;
    logic [2:0] mult_i = 3'd0;
    logic       wide_i = 1'b0;
    logic       ext_bclk_i = 1'b0;
    logic       ext_fclk_i = 1'b0;
    logic       mclk_o, bclk_o, fclk_o, clk_oe_o;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    bit done = 0;
    bit mid_mult = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_clkgen u_audio_clkgen (
        .clk(clk), .rst(rst), .run_i(run_i), .slave_i(slave_i),
        .base384_i(base384_i), .mult_i(mult_i), .wide_i(wide_i),
        .ext_bclk_i(ext_bclk_i), .ext_fclk_i(ext_fclk_i),
        .mclk_o(mclk_o), .bclk_o(bclk_o), .fclk_o(fclk_o), .clk_oe_o(clk_oe_o)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: got %b expected %b", tag, what, $time, act, exp);
        end
    endtask

    // Reference model: frame position as an integer.
    always @(posedge clk) begin
        int per;
        per = base384_i ? 768 : 1024;
        if (rst || !run_i || slave_i) ph = 0;
        else if (ph >= per - 1)       ph = 0;
        else                          ph = ph + 1;
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int per, half, mmax;
            logic em, eb, ef;
            string tm, tb;
            per  = base384_i ? 768 : 1024;
            half = base384_i ? (wide_i ? 8 : 12) : 16;
            mmax = base384_i ? 3 : 4;
            if (slave_i) begin
                chk("R9", "mclk", mclk_o, 1'b0);
                chk("R9", "bclk", bclk_o, ext_bclk_i);
                chk("R9", "fclk", fclk_o, ext_fclk_i);
                chk("R9", "oe", clk_oe_o, 1'b0);
            end else if (!run_i) begin
                chk("R10", "mclk", mclk_o, 1'b0);
                chk("R10", "bclk", bclk_o, 1'b0);
                chk("R10", "fclk", fclk_o, 1'b0);
            end else begin
                em = (int'(mult_i) > mmax) ? 1'b0 : 1'(((ph >> mult_i) & 1));
                eb = 1'(((ph / half) % 2));
                ef = (ph >= per / 2);
                if (mid_mult)               tm = "R11";
                else if (int'(mult_i) > mmax) tm = "R5";
                else if (base384_i)         tm = "R4";
                else                        tm = "R3";
                if (base384_i && wide_i)    tb = "R7";
                else if (wide_i)            tb = "R8";
                else                        tb = "R6";
                chk(tm, "mclk", mclk_o, em);
                chk(tb, "bclk", bclk_o, eb);
                chk("R2", "fclk", fclk_o, ef);
                chk("R9", "oe", clk_oe_o, 1'b1);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic run_cfg(logic b, logic [2:0] m, logic w);
        run_i = 1'b0;
        base384_i = b;
        mult_i = m;
        wide_i = w;
        step(3);
        run_i = 1'b1;
        step(b ? 1560 : 2060);
        run_i = 1'b0;
        step(3);
    endtask

    initial begin
        step(5);
        rst = 1'b0;
        step(1);
        // R1: first cycle after reset
        chk("R1", "mclk", mclk_o, 1'b0);
        chk("R1", "bclk", bclk_o, 1'b0);
        chk("R1", "fclk", fclk_o, 1'b0);
        chk("R1", "oe", clk_oe_o, 1'b1);

        run_cfg(1'b0, 3'd0, 1'b0);
        run_cfg(1'b0, 3'd2, 1'b0);
        run_cfg(1'b0, 3'd4, 1'b0);
        run_cfg(1'b0, 3'd5, 1'b1);
        run_cfg(1'b1, 3'd0, 1'b0);
        run_cfg(1'b1, 3'd3, 1'b1);
        run_cfg(1'b1, 3'd4, 1'b0);
        run_cfg(1'b1, 3'd1, 1'b1);

        // R11: multiplier change mid-frame
        base384_i = 1'b0; mult_i = 3'd1; wide_i = 1'b0;
        run_i = 1'b1;
        step(301);
        mid_mult = 1'b1;
        mult_i = 3'd3;
        step(900);
        mult_i = 3'd0;
        step(77);
        mid_mult = 1'b0;

        // R10: stop mid-frame then restart
        run_i = 1'b0;
        step(4);
        run_i = 1'b1;
        step(700);

        // R9: slave pass-through, then back to master while running
        slave_i = 1'b1;
        for (int i = 0; i < 240; i++) begin
            ext_bclk_i = 1'((i / 3) % 2);
            ext_fclk_i = 1'((i / 7) % 2);
            step(1);
        end
        slave_i = 1'b0;
        step(1100);
        run_i = 1'b0;
        step(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t: got running expected finished", $time);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule